// File: doc/BRIEF.md
# SMI Feature Handshake and Trigger

This block lets boot firmware agree with the platform on a set of system-management-interrupt (SMI) features, then turns writes to the power-management command port into SMI requests. The platform offers a 64-bit set of supported features on `host_feat`. Firmware writes the set it wants into a requested-features register, then writes the confirmation strobe. The block checks the request against the offer and against the dependency rules between features. If the request passes, the block copies it into the negotiated register and raises `feat_ok`. From then on the agreement is frozen until reset.

The block also holds the SMI-enable register and a one-way lock bit. A command-port byte equal to 0xF0 or 0xF1 only produces an ACPI enable or disable pulse. Any other byte produces an SMI request pulse, but only when APMC enable (bit 5 of SMI-enable) is set. That pulse goes to every CPU when broadcast (feature bit 0) was negotiated, and otherwise to the issuing CPU alone.

The negotiation controller is a three-state machine:
- `NEG_OPEN` waits for the confirmation strobe; the strobe moves it to `NEG_CHECK`.
- `NEG_CHECK` spends one cycle evaluating the request. A valid request moves it to `NEG_LOCKED`; an invalid one returns it to `NEG_OPEN`.
- `NEG_LOCKED` is left only through reset.

Top module: `smi_feature_gate`

## Requirements
- R1: While reset is held and right after it, `req_rd`, `neg_feat`, `smi_en_q`, `smi_lock`, `smi_req`, `feat_ok`, `acpi_on_pulse` and `acpi_off_pulse` are all zero.
- R2: A confirmation strobe on a valid request makes `feat_ok` read 1 from the second rising edge after the strobe's edge. At that point `neg_feat` equals the requested set.
- R3: A request holding any bit not set in `host_feat` is rejected: `feat_ok` and `neg_feat` stay 0, and a later valid request can still be confirmed.
- R4: A request with CPU hotplug (bit 1) or CPU hot-unplug (bit 2) but without broadcast (bit 0) is rejected.
- R5: A request with hot-unplug (bit 2) but without hotplug (bit 1) is rejected.
- R6: Once `feat_ok` is 1, further confirmation strobes and new requested values leave `feat_ok` and `neg_feat` unchanged until reset.
- R7: A command write of 0xF0 gives a one-cycle `acpi_on_pulse`, and 0xF1 gives a one-cycle `acpi_off_pulse`. The pulse is visible after the edge that takes the write. Neither code ever raises `smi_req`.
- R8: Any other command write with bit 5 of `smi_en_q` set gives a one-cycle `smi_req` pulse after the edge that takes the write. The pulse is all ones if bit 0 of `neg_feat` is set, and otherwise only bit `cmd_cpu`. With bit 5 clear, no pulse appears.
- R9: Writing 1 to `smi_lock` sets it for good. While it is set, bit 0 of `smi_en_q` keeps its value on writes, and the other bits still take the written data.
- R10: `req_rd` returns the last value written to the requested register, whatever the negotiation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_feat | input | 64 | Features the platform offers |
| req_wr_en | input | 1 | Write strobe for the requested-features register |
| req_wr_data | input | 64 | Requested-features write data |
| req_rd | output | 64 | Requested-features readback |
| ok_wr_en | input | 1 | Confirmation strobe that starts validation |
| feat_ok | output | 1 | Negotiation succeeded and is locked |
| neg_feat | output | 64 | Negotiated feature set |
| smi_en_wr_en | input | 1 | SMI-enable write strobe |
| smi_en_wr_data | input | 32 | SMI-enable write data |
| smi_en_q | output | 32 | SMI-enable register |
| lock_wr_en | input | 1 | Lock write strobe |
| lock_wr_data | input | 1 | Lock write data |
| smi_lock | output | 1 | Lock bit |
| cmd_wr_en | input | 1 | Command-port write strobe |
| cmd_data | input | 8 | Command byte |
| cmd_cpu | input | 2 | Index of the writing CPU |
| smi_req | output | 4 | Per-CPU SMI request pulses |
| acpi_on_pulse | output | 1 | ACPI enable pulse |
| acpi_off_pulse | output | 1 | ACPI disable pulse |

## Verification
A controller stuck in or wrongly leaving the locked state shows at the ports within two cycles of the next confirmation strobe. `feat_ok` then has the wrong value, and the next command write fans its SMI out wrongly one cycle later.

A validation rule applied wrongly shows as a wrong `feat_ok` or `neg_feat` two edges after the strobe. A wrong SMI-enable or lock state shows on the register readback at once, and on the next command write one cycle later.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
    localparam int FEAT_W    = 64;
    localparam int F_BCAST   = 0;
    localparam int F_HOTPLUG = 1;
    localparam int F_UNPLUG  = 2;
    localparam int SMIEN_APMC = 5;
    localparam logic [7:0] CMD_ACPI_ON  = 8'hF0;
    localparam logic [7:0] CMD_ACPI_OFF = 8'hF1;

    typedef enum logic [1:0] {
        NEG_OPEN   = 2'd0,
        NEG_CHECK  = 2'd1,
        NEG_LOCKED = 2'd2
    } neg_state_t;

    function automatic logic feat_acceptable(input logic [FEAT_W-1:0] req,
                                             input logic [FEAT_W-1:0] host);
        logic extra, cpu_any;
        extra   = |(req & ~host);
        cpu_any = req[F_HOTPLUG] | req[F_UNPLUG];
        if (extra) return 1'b0;
        if (cpu_any && !req[F_BCAST]) return 1'b0;
        if (req[F_UNPLUG] && !req[F_HOTPLUG]) return 1'b0;
        return 1'b1;
    endfunction
endpackage

// File: rtl/smi_feat_negotiator.sv
module smi_feat_negotiator
    import smi_neg_pkg::*;
#(
    parameter int W = FEAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] host_feat,
    input  logic         req_wr_en,
    input  logic [W-1:0] req_wr_data,
    input  logic         ok_wr_en,
    output logic [W-1:0] req_q,
    output logic [W-1:0] neg_q,
    output logic         feat_ok
);
    neg_state_t state_q, state_d;
    logic       accept;

    assign accept = feat_acceptable(req_q, host_feat);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NEG_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NEG_OPEN:   if (ok_wr_en) state_d = NEG_CHECK;
            NEG_CHECK:  state_d = accept ? NEG_LOCKED : NEG_OPEN;
            NEG_LOCKED: state_d = NEG_LOCKED;
            default:    state_d = NEG_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            neg_q <= '0;
        end else begin
            if (req_wr_en) req_q <= req_wr_data;
            if (state_q == NEG_CHECK && accept) neg_q <= req_q;
        end
    end

    assign feat_ok = (state_q == NEG_LOCKED);

    p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |=> feat_ok && $stable(neg_q));
    p_only_on_success_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (neg_q != '0) |-> feat_ok);
    p_offered_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |-> ((neg_q & ~host_feat) == '0));
    p_bcast_dep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |-> !((neg_q[F_HOTPLUG] || neg_q[F_UNPLUG]) && !neg_q[F_BCAST]));
    p_unplug_dep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        feat_ok |-> !(neg_q[F_UNPLUG] && !neg_q[F_HOTPLUG]));
endmodule

// File: rtl/smi_cmd_unit.sv
module smi_cmd_unit
    import smi_neg_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int IDX_W    = 2,
    parameter int EN_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smi_en_wr_en,
    input  logic [EN_W-1:0]     smi_en_wr_data,
    input  logic                lock_wr_en,
    input  logic                lock_wr_data,
    input  logic                cmd_wr_en,
    input  logic [7:0]          cmd_data,
    input  logic [IDX_W-1:0]    cmd_cpu,
    input  logic                bcast,
    output logic [EN_W-1:0]     smi_en_q,
    output logic                lock_q,
    output logic [NUM_CPUS-1:0] smi_req,
    output logic                acpi_on,
    output logic                acpi_off
);
    logic                is_on, is_off, fire;
    logic [NUM_CPUS-1:0] target;

    assign is_on  = (cmd_data == CMD_ACPI_ON);
    assign is_off = (cmd_data == CMD_ACPI_OFF);
    assign fire   = cmd_wr_en && !is_on && !is_off && smi_en_q[SMIEN_APMC];
    assign target = bcast ? {NUM_CPUS{1'b1}} : (NUM_CPUS'(1) << cmd_cpu);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_en_q <= '0;
            lock_q   <= 1'b0;
        end else begin
            if (smi_en_wr_en)
                smi_en_q <= {smi_en_wr_data[EN_W-1:1],
                             lock_q ? smi_en_q[0] : smi_en_wr_data[0]};
            if (lock_wr_en && !lock_q)
                lock_q <= lock_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smi_req  <= '0;
            acpi_on  <= 1'b0;
            acpi_off <= 1'b0;
        end else begin
            acpi_on  <= cmd_wr_en && is_on;
            acpi_off <= cmd_wr_en && is_off;
            smi_req  <= fire ? target : '0;
        end
    end

    p_acpi_no_smi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acpi_on || acpi_off) |-> (smi_req == '0));
    p_smi_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req != '0) |-> ($past(cmd_wr_en) && $past(smi_en_q[SMIEN_APMC])));
    p_single_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((smi_req != '0) && !$past(bcast)) |-> ($countones(smi_req) == 1));
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q && $stable(smi_en_q[0]));
endmodule

// File: rtl/smi_feature_gate.sv
module smi_feature_gate
    import smi_neg_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    parameter int EN_W     = 32,
    localparam int IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FEAT_W-1:0]   host_feat,
    input  logic                req_wr_en,
    input  logic [FEAT_W-1:0]   req_wr_data,
    output logic [FEAT_W-1:0]   req_rd,
    input  logic                ok_wr_en,
    output logic                feat_ok,
    output logic [FEAT_W-1:0]   neg_feat,
    input  logic                smi_en_wr_en,
    input  logic [EN_W-1:0]     smi_en_wr_data,
    output logic [EN_W-1:0]     smi_en_q,
    input  logic                lock_wr_en,
    input  logic                lock_wr_data,
    output logic                smi_lock,
    input  logic                cmd_wr_en,
    input  logic [7:0]          cmd_data,
    input  logic [IDX_W-1:0]    cmd_cpu,
    output logic [NUM_CPUS-1:0] smi_req,
    output logic                acpi_on_pulse,
    output logic                acpi_off_pulse
);
    smi_feat_negotiator #(.W(FEAT_W)) u_neg (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_feat   (host_feat),
        .req_wr_en   (req_wr_en),
        .req_wr_data (req_wr_data),
        .ok_wr_en    (ok_wr_en),
        .req_q       (req_rd),
        .neg_q       (neg_feat),
        .feat_ok     (feat_ok)
    );

    smi_cmd_unit #(.NUM_CPUS(NUM_CPUS), .IDX_W(IDX_W), .EN_W(EN_W)) u_cmd (
        .clk            (clk),
        .rst_n          (rst_n),
        .smi_en_wr_en   (smi_en_wr_en),
        .smi_en_wr_data (smi_en_wr_data),
        .lock_wr_en     (lock_wr_en),
        .lock_wr_data   (lock_wr_data),
        .cmd_wr_en      (cmd_wr_en),
        .cmd_data       (cmd_data),
        .cmd_cpu        (cmd_cpu),
        .bcast          (neg_feat[F_BCAST]),
        .smi_en_q       (smi_en_q),
        .lock_q         (smi_lock),
        .smi_req        (smi_req),
        .acpi_on        (acpi_on_pulse),
        .acpi_off       (acpi_off_pulse)
    );
endmodule

// File: tb/smi_feature_gate_tb_top.sv
`timescale 1ns/1ps
module smi_feature_gate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] host_feat = 64'h7;
    logic        req_wr_en = 1'b0;
    logic [63:0] req_wr_data = '0;
    logic [63:0] req_rd;
    logic        ok_wr_en = 1'b0;
    logic        feat_ok;
    logic [63:0] neg_feat;
    logic        smi_en_wr_en = 1'b0;
    logic [31:0] smi_en_wr_data = '0;
    logic [31:0] smi_en_q;
    logic        lock_wr_en = 1'b0;
    logic        lock_wr_data = 1'b0;
    logic        smi_lock;
    logic        cmd_wr_en = 1'b0;
    logic [7:0]  cmd_data = '0;
    logic [1:0]  cmd_cpu = '0;
    logic [3:0]  smi_req;
    logic        acpi_on_pulse, acpi_off_pulse;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    smi_feature_gate dut_i (.*);

    function automatic logic exp_ok(input logic [63:0] r, input logic [63:0] h);
        if ((r & ~h) != 64'd0) return 1'b0;
        if ((r[1] || r[2]) && !r[0]) return 1'b0;
        if (r[2] && !r[1]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [3:0] exp_smi(input logic [7:0] d, input logic en5,
                                           input logic bc, input logic [1:0] cpu);
        if (d == 8'hF0 || d == 8'hF1 || !en5) return 4'd0;
        return bc ? 4'hF : (4'd1 << cpu);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [63:0] h);
        @(negedge clk);
        rst_n = 1'b0;
        host_feat = h;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_req(input logic [63:0] v);
        req_wr_en = 1'b1; req_wr_data = v;
        @(negedge clk);
        req_wr_en = 1'b0;
    endtask

    task automatic confirm();
        ok_wr_en = 1'b1;
        @(negedge clk);
        ok_wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_en(input logic [31:0] v);
        smi_en_wr_en = 1'b1; smi_en_wr_data = v;
        @(negedge clk);
        smi_en_wr_en = 1'b0;
    endtask

    task automatic wr_lock(input logic v);
        lock_wr_en = 1'b1; lock_wr_data = v;
        @(negedge clk);
        lock_wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d, input logic [1:0] cpu,
                       input logic en5, input logic bc, input string tag);
        cmd_wr_en = 1'b1; cmd_data = d; cmd_cpu = cpu;
        @(negedge clk);
        cmd_wr_en = 1'b0;
        chk({tag, " smi"}, 64'(smi_req), 64'(exp_smi(d, en5, bc, cpu)));
        chk({tag, " on"}, 64'(acpi_on_pulse), 64'(d == 8'hF0));
        chk({tag, " off"}, 64'(acpi_off_pulse), 64'(d == 8'hF1));
        @(negedge clk);
        chk({tag, " width"}, 64'({smi_req, acpi_on_pulse, acpi_off_pulse}), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1 reset state
        @(negedge clk);
        chk("R1 during reset", {req_rd[31:0], smi_en_q}, 64'd0);
        do_reset(64'h7);
        chk("R1 req", req_rd, 0);
        chk("R1 neg", neg_feat, 0);
        chk("R1 misc", 64'({feat_ok, smi_lock, smi_req, acpi_on_pulse, acpi_off_pulse}), 0);
        chk("R1 smi_en", 64'(smi_en_q), 0);

        // R3, R4, R5 rejections then R2 success, R6 freeze, R10 readback
        wr_req(64'h8);          confirm();
        chk("R3 ok", 64'(feat_ok), 0);   chk("R3 neg", neg_feat, 0);
        wr_req(64'h2);          confirm();
        chk("R4 hotplug alone", 64'(feat_ok), 0);
        wr_req(64'h4);          confirm();
        chk("R4 unplug alone", 64'(feat_ok), 0);
        wr_req(64'h5);          confirm();
        chk("R5 unplug no hotplug", 64'(feat_ok), 0);
        wr_req(64'h3);
        chk("R10 readback", req_rd, 64'h3);
        ok_wr_en = 1'b1; @(negedge clk); ok_wr_en = 1'b0;
        chk("R2 not yet", 64'(feat_ok), 0);
        @(negedge clk);
        chk("R2 ok", 64'(feat_ok), 1);   chk("R2 neg", neg_feat, 64'h3);
        wr_req(64'h7);
        chk("R10 readback locked", req_rd, 64'h7);
        confirm();
        chk("R6 ok", 64'(feat_ok), 1);   chk("R6 neg", neg_feat, 64'h3);

        // random negotiation
        for (int i = 0; i < 60; i++) begin
            logic [63:0] h, r;
            h = 64'($urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) h[40] = 1'b1;
            r = 64'($urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) r[40] = 1'b1;
            do_reset(h);
            wr_req(r);
            confirm();
            chk("R2-rand ok", 64'(feat_ok), 64'(exp_ok(r, h)));
            chk("R3-rand neg", neg_feat, exp_ok(r, h) ? r : 64'd0);
        end

        // commands: R7, R8
        do_reset(64'h7);
        cmd(8'h33, 2'd1, 1'b0, 1'b0, "R8 disabled");
        wr_en(32'h20);
        cmd(8'hF0, 2'd0, 1'b1, 1'b0, "R7 acpi on");
        cmd(8'hF1, 2'd3, 1'b1, 1'b0, "R7 acpi off");
        cmd(8'h55, 2'd2, 1'b1, 1'b0, "R8 single");
        wr_req(64'h1); confirm();
        cmd(8'h55, 2'd2, 1'b1, 1'b1, "R8 broadcast");
        cmd(8'hF0, 2'd2, 1'b1, 1'b1, "R7 acpi on bcast");
        for (int i = 0; i < 40; i++) begin
            logic [7:0] d; logic e5; logic [1:0] c;
            d = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0) d = 8'hF0 | 8'($urandom_range(0, 1));
            e5 = 1'($urandom_range(0, 1));
            c = 2'($urandom_range(0, 3));
            wr_en({26'd0, e5, 5'd0});
            cmd(d, c, e5, 1'b1, "R8-rand bc");
        end
        do_reset(64'h7);
        for (int i = 0; i < 30; i++) begin
            logic [7:0] d; logic e5; logic [1:0] c;
            d = 8'($urandom_range(0, 255));
            e5 = 1'($urandom_range(0, 1));
            c = 2'($urandom_range(0, 3));
            wr_en({26'd0, e5, 5'd0});
            cmd(d, c, e5, 1'b0, "R8-rand single");
        end

        // lock: R9
        do_reset(64'h7);
        wr_en(32'h1);
        chk("R9 bit0 open set", 64'(smi_en_q), 64'h1);
        wr_en(32'h0);
        chk("R9 bit0 open clear", 64'(smi_en_q), 64'h0);
        wr_en(32'h21);
        wr_lock(1'b1);
        chk("R9 lock set", 64'(smi_lock), 1);
        wr_en(32'h40);
        chk("R9 bit0 held", 64'(smi_en_q), 64'h41);
        wr_lock(1'b0);
        chk("R9 lock stays", 64'(smi_lock), 1);
        do_reset(64'h7);
        chk("R1 lock cleared", 64'({smi_lock, smi_en_q}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule